// File: doc/BRIEF.md
# Configuration Request Engine

This block issues Type 0 configuration read and write requests for a PCIe root port on behalf of software. Software fills three header-dword registers and, for a write, a data register. It then sets a single start bit. The engine checks that the header fields are packed legally. It streams the header, and the data dword for a write, over a valid/ready transmit port. It then waits for the completion on a receive port.

When the completion arrives, or when a programmable timeout expires, the engine records a 3-bit completion status. It loads the read-data register and clears the start bit. Software therefore polls a single bit, both to learn that the request has finished and to learn that the registers may be written again. While a request is in flight, writes to the header, data, timeout and control registers are dropped. This keeps the transmitted request intact.

Top module: `cfg_req_engine`

## Requirements
- R1: After reset the start bit and status read 0, read data reads 0, the timeout limit reads 1000, and the transmit port shows no valid dword.
- R2: CSR word map, selected by csr_addr[4:2] with csr_addr[1:0] equal to zero: 0 header dword 0, 1 header dword 1, 2 header dword 2, 3 write data, 4 control (bit 0 start/busy, bits 7:5 status), 5 read data (read only), 6 timeout limit (low 16 bits). Writable registers read back what was written. Unaligned accesses and other indexes read 0 and write nothing.
- R3: A start is accepted only for a legal header. Dword 0 must hold length 1 in bits 9:0, zero in bits 23:10, type 4 in bits 28:24, and format 0 (read) or 2 (write) in bits 31:29. Dword 1 must hold a byte-enable value of 1, 2, 4, 8, 3, 6, 12 or 15 in bits 3:0, with bits 31:4 zero. Dword 2 must have bits 1:0 and 15:12 zero. Otherwise the start bit stays 0, the status becomes 3'b010, the read data becomes all ones, and nothing is sent.
- R4: An accepted request sends header dwords 0, 1 and 2 in that order, followed by the data dword when the format is 2. One dword moves per cycle with tx_valid and tx_ready both high. tx_last marks the final dword. The dword and tx_last hold steady while tx_valid is high and tx_ready is low.
- R5: The start bit reads 1 from the cycle after an accepted start until the completion or timeout is taken, and reads 0 on the following cycle.
- R6: A completion is taken only after the final dword has been accepted. cpl_valid at any other time changes no register.
- R7: A taken completion sets the status to cpl_status. A nonzero status loads all ones into read data. A zero status loads cpl_data for a read and leaves read data unchanged for a write.
- R8: With a nonzero limit L, a request still waiting L cycles after its final dword is accepted ends with status 3'b001 and read data all ones. A completion presented in the L-th cycle is still taken. A limit of 0 disables the timeout.
- R9: While the start bit is 1, CSR writes to any register, including the control register, are ignored.
- R10: An accepted start clears the status to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 5 | CSR byte address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data for csr_addr (combinational) |
| tx_valid | output | 1 | Request dword valid |
| tx_ready | input | 1 | Request dword accepted |
| tx_data | output | 32 | Request dword |
| tx_last | output | 1 | Final dword of the request |
| cpl_valid | input | 1 | Completion present |
| cpl_status | input | 3 | Completion status, 0 means success |
| cpl_data | input | 32 | Completion payload dword |

## Verification
The hardest situation to reach is the exact timeout boundary: a completion arriving in the last permitted waiting cycle, or one cycle too late. The bench programs a small limit and counts edges from the cycle its own model enters the waiting phase. It then presents the completion exactly L and L+1 edges after the final handshake. Stray completions are injected while transmission is held back by tx_ready low, and again after a timeout. Register writes are issued during the waiting phase to show that the header and the start bit are locked.

// File: rtl/cfg_req_pkg.sv
package cfg_req_pkg;

  localparam int CSR_AW = 5;

  localparam logic [2:0] RI_HDR0  = 3'd0;
  localparam logic [2:0] RI_HDR1  = 3'd1;
  localparam logic [2:0] RI_HDR2  = 3'd2;
  localparam logic [2:0] RI_WDATA = 3'd3;
  localparam logic [2:0] RI_CTRL  = 3'd4;
  localparam logic [2:0] RI_RDATA = 3'd5;
  localparam logic [2:0] RI_TMO   = 3'd6;

  localparam logic [4:0] TYPE_CFG0 = 5'd4;
  localparam logic [2:0] FMT_RD    = 3'd0;
  localparam logic [2:0] FMT_WR    = 3'd2;

  localparam logic [2:0] CST_OK      = 3'b000;
  localparam logic [2:0] CST_TIMEOUT = 3'b001;
  localparam logic [2:0] CST_BADHDR  = 3'b010;

  // legal byte-enable patterns: size 1/2/4 placed at a byte offset inside the dword
  function automatic logic be_legal(input logic [31:0] dw1);
    logic ok;
    case (dw1[3:0])
      4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'h6, 4'hC, 4'hF: ok = 1'b1;
      default: ok = 1'b0;
    endcase
    return ok && (dw1[31:4] == '0);
  endfunction

  function automatic logic dw0_legal(input logic [31:0] dw0);
    return (dw0[9:0] == 10'd1) && (dw0[23:10] == '0) &&
           (dw0[28:24] == TYPE_CFG0) &&
           ((dw0[31:29] == FMT_RD) || (dw0[31:29] == FMT_WR));
  endfunction

  // dw2_rsvd = {dw2[15:12], dw2[1:0]}
  function automatic logic hdr_legal(input logic [31:0] dw0, input logic [31:0] dw1,
                                     input logic [5:0] dw2_rsvd);
    return dw0_legal(dw0) && be_legal(dw1) && (dw2_rsvd == '0);
  endfunction

  function automatic logic carries_data(input logic [2:0] fmt);
    return fmt == FMT_WR;
  endfunction

  function automatic logic [1:0] final_beat(input logic with_data);
    return with_data ? 2'd3 : 2'd2;
  endfunction

endpackage

// File: rtl/cfg_csr_regs.sv
module cfg_csr_regs
  import cfg_req_pkg::*;
#(
  parameter int          TO_W   = 16,
  parameter int unsigned TO_RST = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                csr_we,
  input  logic [CSR_AW-1:0]   csr_addr,
  input  logic [31:0]         csr_wdata,
  output logic [31:0]         csr_rdata,
  input  logic                busy,
  input  logic [2:0]          status,
  input  logic [31:0]         rdata_q,
  output logic [31:0]         hdr0,
  output logic [31:0]         hdr1,
  output logic [31:0]         hdr2,
  output logic [31:0]         wdata,
  output logic [TO_W-1:0]     limit,
  output logic                start_req
);

  localparam int NHDR = 3;

  logic [2:0]  idx;
  logic        aligned;
  logic        wr_ok;
  logic [31:0] hdr_q [NHDR];
  logic [31:0] wdata_q;
  logic [TO_W-1:0] limit_q;

  assign idx     = csr_addr[4:2];
  assign aligned = (csr_addr[1:0] == 2'b00);
  assign wr_ok   = csr_we && aligned && !busy;

  for (genvar g = 0; g < NHDR; g++) begin : g_hdr
    always_ff @(posedge clk) begin
      if (!rst_n)                          hdr_q[g] <= '0;
      else if (wr_ok && idx == 3'(g))      hdr_q[g] <= csr_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wdata_q <= '0;
      limit_q <= TO_W'(TO_RST);
    end else if (wr_ok) begin
      if (idx == RI_WDATA) wdata_q <= csr_wdata;
      if (idx == RI_TMO)   limit_q <= csr_wdata[TO_W-1:0];
    end
  end

  assign start_req = wr_ok && (idx == RI_CTRL) && csr_wdata[0];

  assign hdr0  = hdr_q[0];
  assign hdr1  = hdr_q[1];
  assign hdr2  = hdr_q[2];
  assign wdata = wdata_q;
  assign limit = limit_q;

  always_comb begin
    csr_rdata = '0;
    if (aligned) begin
      case (idx)
        RI_HDR0:  csr_rdata = hdr_q[0];
        RI_HDR1:  csr_rdata = hdr_q[1];
        RI_HDR2:  csr_rdata = hdr_q[2];
        RI_WDATA: csr_rdata = wdata_q;
        RI_CTRL:  csr_rdata = {24'b0, status, 4'b0, busy};
        RI_RDATA: csr_rdata = rdata_q;
        RI_TMO:   csr_rdata[TO_W-1:0] = limit_q;
        default:  csr_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/cfg_tx_seq.sv
module cfg_tx_seq
  import cfg_req_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  logic [31:0] hdr0,
  input  logic [31:0] hdr1,
  input  logic [31:0] hdr2,
  input  logic [31:0] wdata,
  input  logic        with_data,
  input  logic        tx_ready,
  output logic        tx_valid,
  output logic [31:0] tx_data,
  output logic        tx_last,
  output logic        tx_done
);

  logic       sending;
  logic [1:0] beat;
  logic [1:0] last_beat;

  assign last_beat = final_beat(with_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sending <= 1'b0;
      beat    <= '0;
    end else if (launch) begin
      sending <= 1'b1;
      beat    <= '0;
    end else if (sending && tx_ready) begin
      if (beat == last_beat) sending <= 1'b0;
      else                   beat    <= beat + 2'd1;
    end
  end

  always_comb begin
    case (beat)
      2'd0:    tx_data = hdr0;
      2'd1:    tx_data = hdr1;
      2'd2:    tx_data = hdr2;
      default: tx_data = wdata;
    endcase
  end

  assign tx_valid = sending;
  assign tx_last  = sending && (beat == last_beat);
  assign tx_done  = sending && tx_ready && (beat == last_beat);

endmodule

// File: rtl/cfg_cpl_track.sv
module cfg_cpl_track
  import cfg_req_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic            reject,
  input  logic            tx_done,
  input  logic            with_data,
  input  logic            cpl_valid,
  input  logic [2:0]      cpl_status,
  input  logic [31:0]     cpl_data,
  input  logic [TO_W-1:0] limit,
  output logic            go,
  output logic [2:0]      status,
  output logic [31:0]     rdata,
  output logic            waiting,
  output logic            cpl_accept,
  output logic            timeout_fire
);

  logic [TO_W-1:0] wait_cnt;
  logic            armed;

  assign armed        = (limit != '0);
  assign cpl_accept   = waiting && cpl_valid;
  assign timeout_fire = waiting && !cpl_valid && armed && (wait_cnt == limit - TO_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go       <= 1'b0;
      waiting  <= 1'b0;
      wait_cnt <= '0;
      status   <= CST_OK;
      rdata    <= '0;
    end else begin
      if (launch) begin
        go     <= 1'b1;
        status <= CST_OK;
      end
      if (reject) begin
        status <= CST_BADHDR;
        rdata  <= '1;
      end
      if (tx_done) begin
        waiting  <= 1'b1;
        wait_cnt <= '0;
      end else if (cpl_accept) begin
        waiting <= 1'b0;
        go      <= 1'b0;
        status  <= cpl_status;
        if (cpl_status != CST_OK) rdata <= '1;
        else if (!with_data)      rdata <= cpl_data;
      end else if (timeout_fire) begin
        waiting <= 1'b0;
        go      <= 1'b0;
        status  <= CST_TIMEOUT;
        rdata   <= '1;
      end else if (waiting) begin
        wait_cnt <= wait_cnt + TO_W'(1);
      end
    end
  end

endmodule

// File: rtl/cfg_req_engine.sv
module cfg_req_engine
  import cfg_req_pkg::*;
#(
  parameter int          TO_W   = 16,
  parameter int unsigned TO_RST = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic [4:0]  csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [31:0] tx_data,
  output logic        tx_last,
  input  logic        cpl_valid,
  input  logic [2:0]  cpl_status,
  input  logic [31:0] cpl_data
);

  logic [31:0]     hdr0, hdr1, hdr2, wdata;
  logic [TO_W-1:0] limit;
  logic            start_req;
  logic            hdr_ok;
  logic            launch;
  logic            hdr_reject;
  logic            with_data;
  logic            tx_done;
  logic            go;
  logic [2:0]      status_q;
  logic [31:0]     rdata_q;
  logic            waiting;
  logic            cpl_accept;
  logic            timeout_fire;

  assign hdr_ok     = hdr_legal(hdr0, hdr1, {hdr2[15:12], hdr2[1:0]});
  assign launch     = start_req && hdr_ok;
  assign hdr_reject = start_req && !hdr_ok;
  assign with_data  = carries_data(hdr0[31:29]);

  cfg_csr_regs #(.TO_W(TO_W), .TO_RST(TO_RST)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_we    (csr_we),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .busy      (go),
    .status    (status_q),
    .rdata_q   (rdata_q),
    .hdr0      (hdr0),
    .hdr1      (hdr1),
    .hdr2      (hdr2),
    .wdata     (wdata),
    .limit     (limit),
    .start_req (start_req)
  );

  cfg_tx_seq u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .hdr0      (hdr0),
    .hdr1      (hdr1),
    .hdr2      (hdr2),
    .wdata     (wdata),
    .with_data (with_data),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .tx_done   (tx_done)
  );

  cfg_cpl_track #(.TO_W(TO_W)) u_cpl (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (launch),
    .reject       (hdr_reject),
    .tx_done      (tx_done),
    .with_data    (with_data),
    .cpl_valid    (cpl_valid),
    .cpl_status   (cpl_status),
    .cpl_data     (cpl_data),
    .limit        (limit),
    .go           (go),
    .status       (status_q),
    .rdata        (rdata_q),
    .waiting      (waiting),
    .cpl_accept   (cpl_accept),
    .timeout_fire (timeout_fire)
  );

endmodule

// File: rtl/cfg_req_engine_chk.sv
module cfg_req_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        csr_we,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [31:0] tx_data,
  input logic        tx_last,
  input logic        cpl_valid,
  input logic [2:0]  cpl_status,
  input logic        go_q,
  input logic [2:0]  status_q,
  input logic [31:0] rdata_q,
  input logic [31:0] hdr0_q,
  input logic [31:0] hdr1_q,
  input logic [31:0] hdr2_q,
  input logic [31:0] wdata_q,
  input logic        waiting,
  input logic        cpl_accept,
  input logic        timeout_fire,
  input logic        hdr_reject,
  input logic        launch
);

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R4

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid); // R4

  AST_TX_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> go_q); // R5

  AST_HDR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    go_q && csr_we |=> $stable(hdr0_q) && $stable(hdr1_q) && $stable(hdr2_q) && $stable(wdata_q)); // R9

  AST_EARLY_CPL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && go_q && !waiting |=> go_q && $stable(status_q)); // R6

  AST_CPL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_accept |=> !go_q && (status_q == $past(cpl_status))); // R7

  AST_TIMEOUT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_fire |=> !go_q && (status_q == 3'b001) && (rdata_q == 32'hFFFF_FFFF)); // R8

  AST_BAD_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_reject |=> !go_q && !tx_valid && (status_q == 3'b010)); // R3

  AST_LAUNCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> go_q && (status_q == 3'b000)); // R10

endmodule

bind cfg_req_engine cfg_req_engine_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .csr_we       (csr_we),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .tx_data      (tx_data),
  .tx_last      (tx_last),
  .cpl_valid    (cpl_valid),
  .cpl_status   (cpl_status),
  .go_q         (go),
  .status_q     (status_q),
  .rdata_q      (rdata_q),
  .hdr0_q       (hdr0),
  .hdr1_q       (hdr1),
  .hdr2_q       (hdr2),
  .wdata_q      (wdata),
  .waiting      (waiting),
  .cpl_accept   (cpl_accept),
  .timeout_fire (timeout_fire),
  .hdr_reject   (hdr_reject),
  .launch       (launch)
);

// File: tb/cfg_req_engine_test.sv
module cfg_req_engine_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [4:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [31:0] tx_data;
  logic        tx_last;
  logic        cpl_valid = 1'b0;
  logic [2:0]  cpl_status = '0;
  logic [31:0] cpl_data = '0;

  int checks = 0;
  int fails = 0;
  int beats = 0;
  bit finished = 0;
  bit ready_rand = 0;
  bit ready_force = 1;

  // reference model state
  int          m_st = 0;      // 0 idle, 1 sending, 2 waiting
  int          m_beat = 0;
  int          m_cnt = 0;
  logic [31:0] m_hdr [3];
  logic [31:0] m_wd;
  bit          m_go;
  logic [2:0]  m_stat;
  logic [31:0] m_rd;
  logic [31:0] m_lim;

  always #2 clk = ~clk;   // 250 MHz

  cfg_req_engine uut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_data(cpl_data)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit m_is_wr();
    return m_hdr[0][31:29] == 3'd2;
  endfunction

  function automatic int m_last();
    return m_is_wr() ? 3 : 2;
  endfunction

  function automatic bit m_hdr_ok();
    bit be_fine;
    be_fine = 0;
    for (int sz = 1; sz <= 4; sz = sz * 2)
      for (int off = 0; off + sz <= 4; off++)
        if (m_hdr[1] == 32'(((1 << sz) - 1) << off)) be_fine = 1;
    return be_fine && m_hdr[0][9:0] == 10'd1 && m_hdr[0][23:10] == 14'd0 &&
           m_hdr[0][28:24] == 5'd4 && (m_hdr[0][31:29] == 3'd0 || m_hdr[0][31:29] == 3'd2) &&
           m_hdr[2][1:0] == 2'd0 && m_hdr[2][15:12] == 4'd0;
  endfunction

  function automatic logic [31:0] m_read(input logic [4:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a[4:2])
      3'd0: return m_hdr[0];
      3'd1: return m_hdr[1];
      3'd2: return m_hdr[2];
      3'd3: return m_wd;
      3'd4: return {24'h0, m_stat, 4'h0, m_go};
      3'd5: return m_rd;
      3'd6: return m_lim;
      default: return 32'h0;
    endcase
  endfunction

  // model advances on each rising edge from the inputs held since the last one
  always @(posedge clk) begin
    bit old_go;
    if (!rst_n) begin
      m_st = 0; m_beat = 0; m_cnt = 0;
      for (int i = 0; i < 3; i++) m_hdr[i] = 32'h0;
      m_wd = 0; m_go = 0; m_stat = 0; m_rd = 0; m_lim = 1000;
    end else begin
      old_go = m_go;
      if (m_st == 1) begin
        if (tx_ready) begin
          if (m_beat == m_last()) begin m_st = 2; m_cnt = 0; end
          else m_beat++;
        end
      end else if (m_st == 2) begin
        if (cpl_valid) begin
          m_st = 0; m_go = 0; m_stat = cpl_status;
          if (cpl_status != 0) m_rd = 32'hFFFF_FFFF;
          else if (!m_is_wr()) m_rd = cpl_data;
        end else if (m_lim != 0 && m_cnt == int'(m_lim) - 1) begin
          m_st = 0; m_go = 0; m_stat = 3'b001; m_rd = 32'hFFFF_FFFF;
        end else m_cnt++;
      end
      if (csr_we && !old_go && csr_addr[1:0] == 2'b00) begin
        case (csr_addr[4:2])
          3'd0, 3'd1, 3'd2: m_hdr[csr_addr[4:2]] = csr_wdata;
          3'd3: m_wd = csr_wdata;
          3'd4: if (csr_wdata[0]) begin
                  if (m_hdr_ok()) begin m_go = 1; m_stat = 0; m_st = 1; m_beat = 0; end
                  else begin m_stat = 3'b010; m_rd = 32'hFFFF_FFFF; end
                end
          3'd6: m_lim = {16'h0, csr_wdata[15:0]};
          default: ;
        endcase
      end
    end
  end

  // cycle-by-cycle comparison, half a period after the edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk({31'h0, tx_valid}, {31'h0, m_st == 1}, "R4 tx_valid");
      if (m_st == 1) begin
        chk(tx_data, (m_beat == 3) ? m_wd : m_hdr[m_beat], "R4 tx_data order");
        chk({31'h0, tx_last}, {31'h0, m_beat == m_last()}, "R4 tx_last");
      end
      chk(csr_rdata, m_read(csr_addr), "R2 R5 csr readback");
      if (tx_valid && tx_ready) beats++;
    end
  end

  always @(posedge clk) begin
    #1;
    tx_ready = ready_rand ? ($urandom % 2 == 1) : ready_force;
  end

  task automatic csr_wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    csr_we = 1; csr_addr = a; csr_wdata = d;
    @(posedge clk); #1;
    csr_we = 0;
  endtask

  task automatic csr_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
    @(posedge clk); #1;
    csr_addr = a;
    @(negedge clk);
    chk(csr_rdata, exp, req);
  endtask

  task automatic launch_req(input logic [31:0] d0, input logic [31:0] d1,
                            input logic [31:0] d2, input logic [31:0] wd);
    csr_wr(5'h00, d0); csr_wr(5'h04, d1); csr_wr(5'h08, d2); csr_wr(5'h0C, wd);
    csr_wr(5'h10, 32'h1);
  endtask

  task automatic wait_for_cpl_phase();
    @(negedge clk);
    while (m_st != 2) @(negedge clk);
  endtask

  // called in the first waiting cycle; completion is sampled k edges after the final dword
  task automatic give_cpl(input int k, input logic [2:0] st, input logic [31:0] d);
    repeat (k - 1) @(posedge clk);
    #1; cpl_valid = 1; cpl_status = st; cpl_data = d;
    @(posedge clk); #1; cpl_valid = 0;
  endtask

  task automatic pulse_cpl(input logic [2:0] st, input logic [31:0] d);
    @(posedge clk); #1; cpl_valid = 1; cpl_status = st; cpl_data = d;
    @(posedge clk); #1; cpl_valid = 0;
  endtask

  function automatic logic [31:0] mk_dw2(input int bus, input int dev, input int fn, input int off);
    return 32'(bus * 16777216 + dev * 524288 + fn * 65536 + (off / 4) * 4);
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  localparam logic [31:0] RD0 = 32'h0400_0001;
  localparam logic [31:0] WR0 = 32'h4400_0001;

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    csr_chk(5'h10, 32'h0, "R1 control after reset");
    csr_chk(5'h14, 32'h0, "R1 read data after reset");
    csr_chk(5'h18, 32'd1000, "R1 timeout limit after reset");
    chk({31'h0, tx_valid}, 32'h0, "R1 tx idle");

    // R2 register map and unaligned access
    csr_wr(5'h0C, 32'hA5A5_5A5A);
    csr_chk(5'h0C, 32'hA5A5_5A5A, "R2 write data readback");
    csr_wr(5'h0D, 32'h1111_1111);
    csr_chk(5'h0C, 32'hA5A5_5A5A, "R2 unaligned write ignored");
    csr_chk(5'h0D, 32'h0, "R2 unaligned read zero");
    csr_wr(5'h14, 32'h1234_5678);
    csr_chk(5'h14, 32'h0, "R2 read data is read only");

    // R4 R5 R7 plain read, full dword
    beats = 0;
    launch_req(RD0, 32'hF, mk_dw2(3, 5, 2, 16'h40), 32'h0);
    csr_chk(5'h10, 32'h1, "R5 start bit reads busy");
    wait_for_cpl_phase();
    give_cpl(3, 3'b000, 32'hCAFE_F00D);
    csr_chk(5'h10, 32'h0, "R5 R7 cleared, status ok");
    csr_chk(5'h14, 32'hCAFE_F00D, "R7 read payload");
    chk(beats, 3, "R4 three header dwords for read");

    // R4 R7 write with random backpressure, read data unchanged
    beats = 0;
    ready_rand = 1;
    launch_req(WR0, 32'hC, mk_dw2(1, 0, 0, 16'h8), 32'hBEEF_0000);
    wait_for_cpl_phase();
    ready_rand = 0; ready_force = 1;
    give_cpl(2, 3'b000, 32'h0);
    csr_chk(5'h14, 32'hCAFE_F00D, "R7 write leaves read data");
    chk(beats, 4, "R4 header plus data dword for write");

    // R6 completion while still sending is ignored
    ready_force = 0;
    launch_req(RD0, 32'h1, mk_dw2(0, 1, 0, 16'h4), 32'h0);
    pulse_cpl(3'b100, 32'h0BAD_0BAD);
    csr_chk(5'h10, 32'h1, "R6 early completion ignored");
    ready_force = 1;
    wait_for_cpl_phase();
    give_cpl(2, 3'b000, 32'h0000_00AB);
    csr_chk(5'h14, 32'h0000_00AB, "R6 later completion taken");

    // R7 failing completion
    launch_req(RD0, 32'h3, mk_dw2(2, 0, 0, 16'h0), 32'h0);
    wait_for_cpl_phase();
    give_cpl(4, 3'b100, 32'h1234_5678);
    csr_chk(5'h10, 32'h80, "R7 status captured");
    csr_chk(5'h14, 32'hFFFF_FFFF, "R7 all ones on failure");

    // R10 new launch clears status
    ready_force = 0;
    launch_req(RD0, 32'h2, mk_dw2(2, 0, 0, 16'h0), 32'h0);
    csr_chk(5'h10, 32'h1, "R10 status cleared by launch");
    ready_force = 1;
    wait_for_cpl_phase();

    // R9 writes while busy are dropped
    csr_wr(5'h00, 32'hDEAD_BEEF);
    csr_wr(5'h0C, 32'h7777_7777);
    csr_wr(5'h18, 32'd5);
    csr_wr(5'h10, 32'h1);
    pulse_cpl(3'b000, 32'h0000_0042);
    csr_chk(5'h00, RD0, "R9 header locked");
    csr_chk(5'h18, 32'd1000, "R9 limit locked");
    csr_chk(5'h10, 32'h0, "R9 control write ignored");
    csr_chk(5'h14, 32'h0000_0042, "R9 completion read");

    // R3 illegal headers
    beats = 0;
    launch_req(32'h0500_0001, 32'hF, 32'h0, 32'h0);
    csr_chk(5'h10, 32'h40, "R3 bad type rejected");
    csr_chk(5'h14, 32'hFFFF_FFFF, "R3 read data ones");
    launch_req(RD0, 32'h9, 32'h0, 32'h0);
    csr_chk(5'h10, 32'h40, "R3 bad byte enables rejected");
    launch_req(32'h2400_0001, 32'hF, 32'h0, 32'h0);
    csr_chk(5'h10, 32'h40, "R3 bad format rejected");
    launch_req(RD0, 32'hF, 32'h0000_1000, 32'h0);
    csr_chk(5'h10, 32'h40, "R3 reserved dword 2 bits rejected");
    chk(beats, 0, "R3 nothing sent");

    // R8 timeout boundaries with limit 6
    csr_wr(5'h18, 32'd6);
    launch_req(RD0, 32'hF, 32'h0, 32'h0);
    wait_for_cpl_phase();
    give_cpl(6, 3'b000, 32'h0000_0055);
    csr_chk(5'h10, 32'h0, "R8 completion in last cycle taken");
    csr_chk(5'h14, 32'h0000_0055, "R8 last cycle payload");
    launch_req(RD0, 32'hF, 32'h0, 32'h0);
    wait_for_cpl_phase();
    give_cpl(7, 3'b000, 32'h0000_0066);
    csr_chk(5'h10, 32'h20, "R8 timeout status");
    csr_chk(5'h14, 32'hFFFF_FFFF, "R8 R6 late completion ignored");

    // R8 limit zero disables timeout
    csr_wr(5'h18, 32'd0);
    launch_req(RD0, 32'hF, 32'h0, 32'h0);
    wait_for_cpl_phase();
    repeat (50) @(posedge clk);
    csr_chk(5'h10, 32'h1, "R8 no timeout with zero limit");
    pulse_cpl(3'b000, 32'h0000_0077);
    csr_chk(5'h14, 32'h0000_0077, "R8 completion after long wait");

    repeat (4) @(posedge clk);
    finish_run();
  end

endmodule